// File: doc/BRIEF.md
# Data Cache Maintenance Sequencer

This block carries out maintenance commands on a two-way set-associative data cache. Each command comes with a 5-bit operation code, an effective (already physical) address and a 32-bit tag-transfer register value. The block owns the tag and data storage of the cache: 64 sets by 2 ways, 64-byte lines held as four 128-bit quadwords. It reads the tag pair of the addressed set and picks a way. Depending on the command it writes a dirty line back to memory, clears the line, or moves a tag word or a single data word between the arrays and the tag-transfer register.

Commands use a start/busy/done handshake. A write-back goes out as a burst of 128-bit beats on a valid/acknowledge port. The block takes no new command until the current one, including its burst, has finished. Instruction-side and branch-target maintenance codes are accepted and retire with no effect. Any code outside the supported set retires with no effect and raises a flag.

Top module: `cmaint_unit`

## Requirements
- R1: After reset `busy`, `done`, `wb_valid`, `unsupported` and `taglo_out` are 0, and at power-up every tag word and data word in the arrays reads as 0.
- R2: The set is address bits 11:6. Index-type commands take the way from address bit 0. Data-word commands pick the quadword by address bits 5:4 and the 32-bit word by bits 3:2; word k sits in bits 32k+31:32k of a 128-bit beat. Load-data (0x11) returns that word on `taglo_out`, and store-data (0x13) writes `taglo_in` into it.
- R3: Hit-type commands (0x1A, 0x18, 0x1C) match a way whose tag bits 31:12 equal address bits 31:12 and whose valid bit (bit 5) is set, trying way 0 before way 1. With no match the command retires with no change to any tag or data.
- R4: Invalidation (0x1A hit, 0x16 index, and the invalidating write-back forms) leaves only the least-recently-filled bit (bit 4) of the tag word and zeroes all four quadwords of that way. 0x16 never writes back.
- R5: A write-back occurs only when the chosen way has both the valid bit (5) and the dirty bit (6) set. It sends four beats in quadword order 0..3. Beat q goes to address {0, tag bits 30:12, set, q, 4'b0000} and is held steady until `mem_ack` is seen.
- R6: Hit write-back-keep (0x1C) writes back a dirty line, then clears only its dirty bit, leaving the line valid with its data intact. A second 0x1C on the now clean line sends no beats.
- R7: Load-tag (0x10) first writes back a valid dirty line and clears its dirty bit, then returns the whole tag word on `taglo_out`. A clean line, or a dirty line that is not valid, is returned unchanged with no burst.
- R8: Store-tag (0x12) writes `taglo_in` into the indexed tag word exactly as given.
- R9: Codes 0x07 and 0x0C retire with `unsupported` low and no effect. Any code outside the nine data-cache codes and these two retires with no effect and `unsupported` high. `unsupported` updates only when `done` pulses.
- R10: `start` is taken only while `busy` is low. `busy` stays high until the command retires, and `done` is a one-cycle pulse in the cycle `busy` falls. A `start` raised while busy, including during a burst, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, taken when not busy |
| opcode | input | 5 | Maintenance operation code |
| addr | input | 32 | Effective address of the command |
| taglo_in | input | 32 | Tag-transfer register value for store commands |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle retire pulse |
| taglo_out | output | 32 | Tag-transfer register value produced by load commands |
| unsupported | output | 1 | Last retired code was not recognised |
| wb_valid | output | 1 | Write-back beat is presented |
| wb_addr | output | 32 | Byte address of the presented beat |
| wb_data | output | 128 | Data of the presented beat |
| mem_ack | input | 1 | Memory accepts the presented beat |

## Verification
A wrong tag word shows up as soon as a later load-tag on that set and way retires. It also shows as a hit command that bursts when it should not, or skips a burst it owes, visible at `wb_valid` within three cycles of the start. Wrong data, or a wrong way chosen on a hit, shows in the beat contents or addresses of a later write-back, or in the word a load-data returns. A mis-sequenced burst shows as a beat count other than zero or four, or as addresses that are not ascending. A command that slips in while busy shows only later, as a tag it should not have written.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;

  // tag word flag positions (behavioural: software reads/writes them)
  localparam int DIRTY_BIT = 6;
  localparam int VALID_BIT = 5;
  localparam int LRF_BIT   = 4;

  typedef enum logic [4:0] {
    OP_LD_TAG     = 5'h10,
    OP_LD_DATA    = 5'h11,
    OP_ST_TAG     = 5'h12,
    OP_ST_DATA    = 5'h13,
    OP_IX_WBINV   = 5'h14,
    OP_IX_INV     = 5'h16,
    OP_HIT_WBINV  = 5'h18,
    OP_HIT_INV    = 5'h1A,
    OP_HIT_WBKEEP = 5'h1C,
    OP_ICACHE_NOP = 5'h07,
    OP_BTC_NOP    = 5'h0C
  } cm_op_e;

  typedef struct packed {
    logic by_hit;
    logic wr_back;
    logic inval;
    logic ld_tag;
    logic ld_data;
    logic st_tag;
    logic st_data;
    logic unsup;
  } cm_ctl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TAGRD,
    S_WB_RD,
    S_WB_LAT,
    S_WB_SEND,
    S_CLR,
    S_DCAP,
    S_FIN
  } cm_state_e;

endpackage

// File: rtl/cmaint_decode.sv
module cmaint_decode
  import cmaint_pkg::*;
(
  input  logic [4:0] op,
  output cm_ctl_t    ctl
);

  always_comb begin
    ctl = '0;
    case (op)
      OP_HIT_INV:    begin ctl.by_hit = 1'b1; ctl.inval = 1'b1; end
      OP_HIT_WBINV:  begin ctl.by_hit = 1'b1; ctl.wr_back = 1'b1; ctl.inval = 1'b1; end
      OP_HIT_WBKEEP: begin ctl.by_hit = 1'b1; ctl.wr_back = 1'b1; end
      OP_IX_INV:     ctl.inval = 1'b1;
      OP_IX_WBINV:   begin ctl.wr_back = 1'b1; ctl.inval = 1'b1; end
      OP_LD_TAG:     begin ctl.wr_back = 1'b1; ctl.ld_tag = 1'b1; end
      OP_LD_DATA:    ctl.ld_data = 1'b1;
      OP_ST_TAG:     ctl.st_tag = 1'b1;
      OP_ST_DATA:    ctl.st_data = 1'b1;
      OP_ICACHE_NOP,
      OP_BTC_NOP:    ctl = '0;
      default:       ctl.unsup = 1'b1;
    endcase
  end

endmodule

// File: rtl/cmaint_sram.sv
module cmaint_sram #(
  parameter int WIDTH = 128,
  parameter int DEPTH = 256,
  parameter int LANES = 4,
  localparam int LANE_W = WIDTH / LANES,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  wlane,
  input  logic [AW-1:0]     waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WIDTH-1:0]  rdata
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    always_ff @(posedge clk) begin
      if (we && wlane[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
      rdata[l*LANE_W +: LANE_W] <= mem[raddr];
    end
  end

endmodule

// File: rtl/cmaint_ctrl.sv
module cmaint_ctrl
  import cmaint_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_SETS   = 64,
  parameter int NUM_WAYS   = 2,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 16,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int BEATS   = LINE_BYTES / BEAT_BYTES,
  localparam int BQ_W    = $clog2(BEATS),
  localparam int BOFF_W  = $clog2(BEAT_BYTES),
  localparam int BEAT_W  = BEAT_BYTES * 8,
  localparam int LANES   = BEAT_BYTES / 4,
  localparam int LSEL_W  = $clog2(LANES),
  localparam int DADDR_W = SET_W + BQ_W,
  localparam int TAG_LSB = OFF_W + SET_W
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  cm_ctl_t                          ctl_in,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [ADDR_W-1:0]                taglo_in,
  input  logic                             mem_ack,
  input  logic [NUM_WAYS-1:0][ADDR_W-1:0]  tag_rd,
  input  logic [NUM_WAYS-1:0][BEAT_W-1:0]  data_rd,
  output logic [SET_W-1:0]                 tag_raddr,
  output logic [NUM_WAYS-1:0]              tag_we,
  output logic [SET_W-1:0]                 tag_waddr,
  output logic [ADDR_W-1:0]                tag_wdata,
  output logic [NUM_WAYS-1:0]              data_we,
  output logic [LANES-1:0]                 data_lane,
  output logic [DADDR_W-1:0]               data_waddr,
  output logic [BEAT_W-1:0]                data_wdata,
  output logic [DADDR_W-1:0]               data_raddr,
  output logic                             busy,
  output logic                             done,
  output logic [ADDR_W-1:0]                taglo_out,
  output logic                             unsupported,
  output logic                             wb_valid,
  output logic [ADDR_W-1:0]                wb_addr,
  output logic [BEAT_W-1:0]                wb_data
);

  cm_state_e           state;
  cm_ctl_t             ctl_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [ADDR_W-1:0]   tl_q;
  logic [WAY_W-1:0]    way_q;
  logic [ADDR_W-1:0]   tag_q;
  logic [ADDR_W-1:0]   tag_new_q;
  logic                tag_upd_q;
  logic [BQ_W-1:0]     beat_q;

  logic [SET_W-1:0]    set_q;
  logic [BQ_W-1:0]     qsel_q;
  logic [LSEL_W-1:0]   wsel_q;

  assign set_q  = addr_q[OFF_W +: SET_W];
  assign qsel_q = addr_q[BOFF_W +: BQ_W];
  assign wsel_q = addr_q[2 +: LSEL_W];

  // way lookup: lowest-numbered matching valid way wins
  logic             hit_any;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] sel_way;
  logic [ADDR_W-1:0] sel_tag;
  logic             proceed;
  logic             sel_dv;

  always_comb begin
    hit_any = 1'b0;
    hit_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (tag_rd[w][VALID_BIT] &&
          tag_rd[w][ADDR_W-1:TAG_LSB] == addr_q[ADDR_W-1:TAG_LSB]) begin
        hit_any = 1'b1;
        hit_way = w[WAY_W-1:0];
      end
    end
    sel_way = ctl_q.by_hit ? hit_way : addr_q[WAY_W-1:0];
    sel_tag = tag_rd[sel_way];
    proceed = !ctl_q.by_hit || hit_any;
    sel_dv  = sel_tag[DIRTY_BIT] && sel_tag[VALID_BIT];
  end

  logic [ADDR_W-1:0] lrf_only;
  logic [ADDR_W-1:0] no_dirty;
  assign lrf_only = tag_q & (ADDR_W'(1) << LRF_BIT);
  assign no_dirty = tag_q & ~(ADDR_W'(1) << DIRTY_BIT);

  // array port steering
  assign tag_raddr  = addr[OFF_W +: SET_W];
  assign tag_waddr  = set_q;
  assign tag_wdata  = tag_new_q;
  assign data_raddr = (state == S_TAGRD) ? {set_q, qsel_q} : {set_q, beat_q};

  always_comb begin
    tag_we = '0;
    if (state == S_FIN && tag_upd_q) tag_we[way_q] = 1'b1;
  end

  always_comb begin
    data_we    = '0;
    data_lane  = '0;
    data_waddr = {set_q, qsel_q};
    data_wdata = {LANES{tl_q}};
    if (state == S_TAGRD && proceed && ctl_q.st_data) begin
      data_we[sel_way] = 1'b1;
      data_lane[wsel_q] = 1'b1;
    end else if (state == S_CLR) begin
      data_we[way_q] = 1'b1;
      data_lane      = '1;
      data_waddr     = {set_q, beat_q};
      data_wdata     = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      ctl_q       <= '0;
      addr_q      <= '0;
      tl_q        <= '0;
      way_q       <= '0;
      tag_q       <= '0;
      tag_new_q   <= '0;
      tag_upd_q   <= 1'b0;
      beat_q      <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      taglo_out   <= '0;
      unsupported <= 1'b0;
      wb_valid    <= 1'b0;
      wb_addr     <= '0;
      wb_data     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            ctl_q     <= ctl_in;
            addr_q    <= addr;
            tl_q      <= taglo_in;
            tag_upd_q <= 1'b0;
            busy      <= 1'b1;
            state     <= S_TAGRD;
          end
        end

        S_TAGRD: begin
          way_q  <= sel_way;
          tag_q  <= sel_tag;
          beat_q <= '0;
          if (!proceed) begin
            state <= S_FIN;
          end else if (ctl_q.st_tag) begin
            tag_new_q <= tl_q;
            tag_upd_q <= 1'b1;
            state     <= S_FIN;
          end else if (ctl_q.st_data) begin
            state <= S_FIN;
          end else if (ctl_q.ld_data) begin
            state <= S_DCAP;
          end else if (ctl_q.wr_back && sel_dv) begin
            state <= S_WB_RD;
          end else if (ctl_q.inval) begin
            state <= S_CLR;
          end else begin
            if (ctl_q.ld_tag) taglo_out <= sel_tag;
            state <= S_FIN;
          end
        end

        S_WB_RD: state <= S_WB_LAT;

        S_WB_LAT: begin
          wb_data  <= data_rd[way_q];
          wb_addr  <= {1'b0, tag_q[ADDR_W-2:TAG_LSB], set_q, beat_q, {BOFF_W{1'b0}}};
          wb_valid <= 1'b1;
          state    <= S_WB_SEND;
        end

        S_WB_SEND: begin
          if (mem_ack) begin
            wb_valid <= 1'b0;
            if (beat_q == BQ_W'(BEATS - 1)) begin
              beat_q <= '0;
              if (ctl_q.inval) begin
                state <= S_CLR;
              end else begin
                tag_new_q <= no_dirty;
                tag_upd_q <= 1'b1;
                if (ctl_q.ld_tag) taglo_out <= no_dirty;
                state <= S_FIN;
              end
            end else begin
              beat_q <= beat_q + 1'b1;
              state  <= S_WB_RD;
            end
          end
        end

        S_CLR: begin
          tag_new_q <= lrf_only;
          tag_upd_q <= 1'b1;
          if (beat_q == BQ_W'(BEATS - 1)) begin
            beat_q <= '0;
            state  <= S_FIN;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end

        S_DCAP: begin
          taglo_out <= data_rd[way_q][wsel_q*32 +: 32];
          state     <= S_FIN;
        end

        S_FIN: begin
          busy        <= 1'b0;
          done        <= 1'b1;
          unsupported <= ctl_q.unsup;
          state       <= S_IDLE;
        end

        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmaint_unit.sv
module cmaint_unit
  import cmaint_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_SETS   = 64,
  parameter int NUM_WAYS   = 2,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 16,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int BEATS   = LINE_BYTES / BEAT_BYTES,
  localparam int BQ_W    = $clog2(BEATS),
  localparam int BEAT_W  = BEAT_BYTES * 8,
  localparam int LANES   = BEAT_BYTES / 4,
  localparam int DADDR_W = SET_W + BQ_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [4:0]        opcode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] taglo_in,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] taglo_out,
  output logic              unsupported,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [BEAT_W-1:0] wb_data,
  input  logic              mem_ack
);

  cm_ctl_t ctl;

  logic [NUM_WAYS-1:0][ADDR_W-1:0] tag_rd;
  logic [NUM_WAYS-1:0][BEAT_W-1:0] data_rd;
  logic [SET_W-1:0]                tag_raddr;
  logic [NUM_WAYS-1:0]             tag_we;
  logic [SET_W-1:0]                tag_waddr;
  logic [ADDR_W-1:0]               tag_wdata;
  logic [NUM_WAYS-1:0]             data_we;
  logic [LANES-1:0]                data_lane;
  logic [DADDR_W-1:0]              data_waddr;
  logic [BEAT_W-1:0]               data_wdata;
  logic [DADDR_W-1:0]              data_raddr;

  cmaint_decode u_dec (
    .op  (opcode),
    .ctl (ctl)
  );

  cmaint_ctrl #(
    .ADDR_W     (ADDR_W),
    .NUM_SETS   (NUM_SETS),
    .NUM_WAYS   (NUM_WAYS),
    .LINE_BYTES (LINE_BYTES),
    .BEAT_BYTES (BEAT_BYTES)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .ctl_in      (ctl),
    .addr        (addr),
    .taglo_in    (taglo_in),
    .mem_ack     (mem_ack),
    .tag_rd      (tag_rd),
    .data_rd     (data_rd),
    .tag_raddr   (tag_raddr),
    .tag_we      (tag_we),
    .tag_waddr   (tag_waddr),
    .tag_wdata   (tag_wdata),
    .data_we     (data_we),
    .data_lane   (data_lane),
    .data_waddr  (data_waddr),
    .data_wdata  (data_wdata),
    .data_raddr  (data_raddr),
    .busy        (busy),
    .done        (done),
    .taglo_out   (taglo_out),
    .unsupported (unsupported),
    .wb_valid    (wb_valid),
    .wb_addr     (wb_addr),
    .wb_data     (wb_data)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    cmaint_sram #(
      .WIDTH (ADDR_W),
      .DEPTH (NUM_SETS),
      .LANES (1)
    ) u_tag (
      .clk   (clk),
      .we    (tag_we[w]),
      .wlane (1'b1),
      .waddr (tag_waddr),
      .wdata (tag_wdata),
      .raddr (tag_raddr),
      .rdata (tag_rd[w])
    );

    cmaint_sram #(
      .WIDTH (BEAT_W),
      .DEPTH (NUM_SETS * BEATS),
      .LANES (LANES)
    ) u_data (
      .clk   (clk),
      .we    (data_we[w]),
      .wlane (data_lane),
      .waddr (data_waddr),
      .wdata (data_wdata),
      .raddr (data_raddr),
      .rdata (data_rd[w])
    );
  end

endmodule

// File: rtl/cmaint_unit_chk.sv
module cmaint_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              unsupported,
  input logic              wb_valid,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [BEAT_W-1:0] wb_data,
  input logic              mem_ack
);

  // R10: retire strobe lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: busy has dropped when the strobe is seen
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10: a burst only runs inside a command
  p_wb_in_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> busy);

  // R5: beat held steady until accepted
  p_wb_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !mem_ack) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

  // R5: beat address has top bit cleared and is beat aligned
  p_wb_addr_r5: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (!wb_addr[ADDR_W-1] && wb_addr[3:0] == 4'h0));

  // R9: the flag moves only on a retire
  p_unsup_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(unsupported));

  // R10: an accepted beat is followed by a dropped valid
  p_wb_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && mem_ack) |=> !wb_valid);

endmodule

bind cmaint_unit cmaint_unit_chk #(
  .ADDR_W (ADDR_W),
  .BEAT_W (BEAT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .unsupported (unsupported),
  .wb_valid    (wb_valid),
  .wb_addr     (wb_addr),
  .wb_data     (wb_data),
  .mem_ack     (mem_ack)
);

// File: tb/cmaint_unit_tb_top.sv
module cmaint_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [4:0]   opcode;
  logic [31:0]  addr;
  logic [31:0]  taglo_in;
  logic         busy;
  logic         done;
  logic [31:0]  taglo_out;
  logic         unsupported;
  logic         wb_valid;
  logic [31:0]  wb_addr;
  logic [127:0] wb_data;
  logic         mem_ack;

  always #10 clk = ~clk;

  cmaint_unit dut_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .opcode      (opcode),
    .addr        (addr),
    .taglo_in    (taglo_in),
    .busy        (busy),
    .done        (done),
    .taglo_out   (taglo_out),
    .unsupported (unsupported),
    .wb_valid    (wb_valid),
    .wb_addr     (wb_addr),
    .wb_data     (wb_data),
    .mem_ack     (mem_ack)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // memory side: logs beats, acknowledges after a short delay
  logic [31:0]  log_addr [16];
  logic [127:0] log_data [16];
  int           log_n = 0;

  initial begin
    mem_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (wb_valid && !mem_ack) begin
        repeat (2) @(negedge clk);
        if (log_n < 16) begin
          log_addr[log_n] = wb_addr;
          log_data[log_n] = wb_data;
        end
        log_n = log_n + 1;
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  task automatic check(input logic [127:0] act, input logic [127:0] exp,
                       input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  logic [31:0] r_tl;
  logic        r_un;

  task automatic run_op(input logic [4:0] op, input logic [31:0] a, input logic [31:0] tl);
    int n;
    @(negedge clk);
    start = 1'b1; opcode = op; addr = a; taglo_in = tl;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 4000) begin
      n_chk++; n_fail++;
      $display("FAIL R10 command %h never retired: got busy %b expected done 1", op, busy);
    end
    r_tl = taglo_out;
    r_un = unsupported;
  endtask

  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] a;
    logic [31:0] tl;
    logic        chk;
    logic [31:0] exp;
    logic        uns;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VT [NV] = '{
    '{5'h12, 32'h000000C0, 32'h12345020, 1'b0, 32'h0,        1'b0, 4'd8}, // R8
    '{5'h12, 32'h000000C1, 32'h0ABCD070, 1'b0, 32'h0,        1'b0, 4'd8}, // R8
    '{5'h10, 32'h000000C0, 32'h0,        1'b1, 32'h12345020, 1'b0, 4'd8}, // R8 R7 clean
    '{5'h13, 32'h000000E4, 32'hDEADBEEF, 1'b0, 32'h0,        1'b0, 4'd2}, // R2
    '{5'h13, 32'h000000E5, 32'h01234567, 1'b0, 32'h0,        1'b0, 4'd2}, // R2
    '{5'h11, 32'h000000E4, 32'h0,        1'b1, 32'hDEADBEEF, 1'b0, 4'd2}, // R2
    '{5'h11, 32'h000000E5, 32'h0,        1'b1, 32'h01234567, 1'b0, 4'd2}, // R2
    '{5'h11, 32'h000000E8, 32'h0,        1'b1, 32'h0,        1'b0, 4'd2}, // R2 neighbour word
    '{5'h07, 32'h0,        32'h0,        1'b0, 32'h0,        1'b0, 4'd9}, // R9
    '{5'h0C, 32'h0,        32'h0,        1'b0, 32'h0,        1'b0, 4'd9}, // R9
    '{5'h1F, 32'h0,        32'h0,        1'b0, 32'h0,        1'b1, 4'd9}, // R9
    '{5'h00, 32'h0,        32'h0,        1'b0, 32'h0,        1'b1, 4'd9}, // R9
    '{5'h1A, 32'h555550C0, 32'h0,        1'b0, 32'h0,        1'b0, 4'd3}, // R3 miss
    '{5'h10, 32'h000000C0, 32'h0,        1'b1, 32'h12345020, 1'b0, 4'd3}, // R3 untouched
    '{5'h1A, 32'h123450C0, 32'h0,        1'b0, 32'h0,        1'b0, 4'd4}, // R4 hit way0
    '{5'h10, 32'h000000C0, 32'h0,        1'b1, 32'h0,        1'b0, 4'd4}, // R4
    '{5'h11, 32'h000000E4, 32'h0,        1'b1, 32'h0,        1'b0, 4'd4}, // R4 data zeroed
    '{5'h11, 32'h000000E5, 32'h0,        1'b1, 32'h01234567, 1'b0, 4'd4}, // R4 other way kept
    '{5'h12, 32'h00000140, 32'h00777020, 1'b0, 32'h0,        1'b0, 4'd3}, // R3
    '{5'h12, 32'h00000141, 32'h00777030, 1'b0, 32'h0,        1'b0, 4'd3}, // R3
    '{5'h1A, 32'h00777140, 32'h0,        1'b0, 32'h0,        1'b0, 4'd3}, // R3 both match
    '{5'h10, 32'h00000140, 32'h0,        1'b1, 32'h0,        1'b0, 4'd3}, // R3 way0 first
    '{5'h10, 32'h00000141, 32'h0,        1'b1, 32'h00777030, 1'b0, 4'd3}, // R3
    '{5'h1A, 32'h00777140, 32'h0,        1'b0, 32'h0,        1'b0, 4'd4}, // R4
    '{5'h10, 32'h00000141, 32'h0,        1'b1, 32'h00000010, 1'b0, 4'd4}, // R4 LRF kept
    '{5'h12, 32'h00000180, 32'h00888040, 1'b0, 32'h0,        1'b0, 4'd5}, // R5 dirty not valid
    '{5'h1A, 32'h00888180, 32'h0,        1'b0, 32'h0,        1'b0, 4'd3}, // R3 invalid no hit
    '{5'h10, 32'h00000180, 32'h0,        1'b1, 32'h00888040, 1'b0, 4'd5}, // R5 R7
    '{5'h16, 32'h000000C1, 32'h0,        1'b0, 32'h0,        1'b0, 4'd4}, // R4 index inval
    '{5'h10, 32'h000000C1, 32'h0,        1'b1, 32'h00000010, 1'b0, 4'd4}, // R4
    '{5'h11, 32'h000000E5, 32'h0,        1'b1, 32'h0,        1'b0, 4'd4}, // R4
    '{5'h11, 32'h000003FC, 32'h0,        1'b1, 32'h0,        1'b0, 4'd1}  // R1 power-up zero
  };

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] exp_q;
    rst = 1'b1; start = 1'b0; opcode = '0; addr = '0; taglo_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy, 0, "R1", "busy after reset");
    check(done, 0, "R1", "done after reset");
    check(wb_valid, 0, "R1", "wb_valid after reset");
    check(unsupported, 0, "R1", "unsupported after reset");
    check(taglo_out, 0, "R1", "taglo_out after reset");
    rst = 1'b0;
    @(negedge clk);

    // vector table
    log_n = 0;
    for (int i = 0; i < NV; i++) begin
      run_op(VT[i].op, VT[i].a, VT[i].tl);
      if (VT[i].chk)
        check(r_tl, VT[i].exp, $sformatf("R%0d", VT[i].req), $sformatf("vector %0d taglo", i));
      check(r_un, VT[i].uns, $sformatf("R%0d", VT[i].req), $sformatf("vector %0d unsupported", i));
    end
    check(log_n, 0, "R5", "no burst from clean, invalid or index-invalidated lines");

    // R10 done pulse width and busy drop
    run_op(5'h07, 32'h0, 32'h0);
    check(busy, 0, "R10", "busy at done");
    @(negedge clk);
    check(done, 0, "R10", "done one cycle");

    // R5 R4 hit write-back-invalidate on way1, with way0 valid under another tag
    run_op(5'h12, 32'h00000280, 32'h11111020);
    run_op(5'h12, 32'h00000281, 32'hCA5A5060);
    for (int q = 0; q < 4; q++)
      for (int w = 0; w < 4; w++)
        run_op(5'h13, 32'h00000281 | (q << 4) | (w << 2), 32'hA0000000 | (q << 8) | w);
    log_n = 0;
    run_op(5'h18, 32'hCA5A5280, 32'h0);
    check(log_n, 4, "R5", "beats for hit wb-inval");
    for (int q = 0; q < 4; q++) begin
      check(log_addr[q], 32'h4A5A5280 + q * 16, "R5", $sformatf("beat %0d address", q));
      exp_q = '0;
      for (int w = 0; w < 4; w++) exp_q[w*32 +: 32] = 32'hA0000000 | (q << 8) | w;
      check(log_data[q], exp_q, "R2", $sformatf("beat %0d data", q));
    end
    run_op(5'h10, 32'h00000281, 32'h0);
    check(r_tl, 32'h0, "R4", "tag after wb-inval");
    run_op(5'h11, 32'h000002B9, 32'h0);
    check(r_tl, 32'h0, "R4", "data after wb-inval");
    run_op(5'h10, 32'h00000280, 32'h0);
    check(r_tl, 32'h11111020, "R3", "way0 untouched");

    // R6 keep variant
    run_op(5'h12, 32'h00000300, 32'h00ABC060);
    run_op(5'h13, 32'h0000031C, 32'h5555AAAA);
    log_n = 0;
    run_op(5'h1C, 32'h00ABC300, 32'h0);
    check(log_n, 4, "R6", "beats for keep");
    check(log_data[1], {32'h5555AAAA, 96'h0}, "R6", "keep beat1 data");
    check(log_addr[3], 32'h00ABC330, "R5", "keep beat3 address");
    run_op(5'h10, 32'h00000300, 32'h0);
    check(r_tl, 32'h00ABC020, "R6", "dirty cleared valid kept");
    run_op(5'h11, 32'h0000031C, 32'h0);
    check(r_tl, 32'h5555AAAA, "R6", "data kept");
    log_n = 0;
    run_op(5'h1C, 32'h00ABC300, 32'h0);
    check(log_n, 0, "R6", "clean keep sends nothing");

    // R7 load-tag on dirty line, with R10 start while busy
    run_op(5'h12, 32'h00000341, 32'h0FEDC070);
    run_op(5'h13, 32'h00000341, 32'h13579BDF);
    log_n = 0;
    fork
      run_op(5'h10, 32'h00000341, 32'h0);
      begin
        repeat (6) @(negedge clk);
        check(busy, 1, "R10", "busy during burst");
        start = 1'b1; opcode = 5'h12; addr = 32'h00000500; taglo_in = 32'hFFFFFFFF;
        @(negedge clk);
        start = 1'b0;
      end
    join
    check(r_tl, 32'h0FEDC030, "R7", "load-tag after write-back");
    check(log_n, 4, "R7", "load-tag burst beats");
    check(log_addr[0], 32'h0FEDC340, "R7", "load-tag burst base");
    check(log_data[0], {96'h0, 32'h13579BDF}, "R7", "load-tag beat0 data");
    run_op(5'h10, 32'h00000500, 32'h0);
    check(r_tl, 32'h0, "R10", "start while busy ignored");
    log_n = 0;
    run_op(5'h10, 32'h00000341, 32'h0);
    check(log_n, 0, "R7", "second load-tag no burst");

    // R5 index write-back-invalidate, top address bit dropped
    run_op(5'h12, 32'h00000380, 32'h80001060);
    log_n = 0;
    run_op(5'h14, 32'h00000380, 32'h0);
    check(log_n, 4, "R5", "index wb-inval beats");
    check(log_addr[0], 32'h00001380, "R5", "index wb-inval base");
    check(log_addr[2], 32'h000013A0, "R5", "index wb-inval beat2");
    run_op(5'h10, 32'h00000380, 32'h0);
    check(r_tl, 32'h0, "R4", "index wb-inval tag");
    log_n = 0;
    run_op(5'h14, 32'h00000380, 32'h0);
    check(log_n, 0, "R5", "clean index wb-inval no burst");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule